// File: doc/BRIEF.md
# Branch Prediction Controller with Outcome Accounting

This unit sits between instruction fetch and branch execution. Each cycle fetch may present a branch PC. The unit looks the PC up in a two-way set-associative target buffer and in a table of 2-bit direction counters. From those two lookups it answers with a taken flag, a predicted target and the next fetch PC. Each cycle execute may also report a resolved branch: its PC, whether it was taken and where it went. That report trains the direction counter. For a taken branch it also writes the target buffer.

A small in-flight table remembers, for each PC, the prediction last issued for it. At resolve time the stored prediction is scored against the actual outcome and then dropped. Five saturating statistics counters track prediction requests, correct and wrong outcomes, and target-buffer hits and misses. A mode input restricts direction training to branches that are already present in the target buffer. This limits pollution of shared counters by untracked branches.

Top module: `bp_ctrl`

## Requirements
- R1: `pred_taken_o` is 1 only when the fetch PC hits in the target buffer and its direction counter is 2 or 3. `pred_target_o` is then the buffered target; otherwise it is 0.
- R2: `pred_next_pc_o` equals `pred_target_o` when the prediction is taken. Otherwise it equals the fetch PC plus FETCH_WIDTH*INST_BYTES, which is 16 by default.
- R3: Each cycle with `pred_req_i` high increments `stat_total_o` by one, visible after the next rising edge.
- R4: Each prediction request increments exactly one of `stat_btb_hit_o` or `stat_btb_miss_o`, according to whether the target-buffer lookup hit.
- R5: The direction counter for a PC sits at index PC[9:1]. It is 2 bits wide and resets to 1. A taken resolution moves it up and a not-taken resolution moves it down, and it saturates at 0 and at 3.
- R6: The target buffer is indexed by PC[7:1] and tagged with PC[31:8]. It is written with the actual target only on a taken resolution. An existing entry for the PC is updated in place. Otherwise an empty way is filled, way 0 before way 1. If both ways are full, the least recently used way is evicted. A prediction hit and a write both make the way most recently used.
- R7: A scored resolution is correct when the predicted direction equals the actual direction and, if the branch was taken, the predicted target equals the actual target. Correct resolutions increment `stat_correct_o`. All other scored resolutions increment `stat_mispred_o`.
- R8: A resolution whose PC has no stored prediction still trains the predictor but changes neither accuracy counter. A stored prediction is removed when its PC resolves, so a second resolve of the same PC is not scored.
- R9: The in-flight table holds INFLIGHT entries, 4 by default. A new prediction for a PC already in the table replaces that entry. Otherwise it goes into slots in rotating order, so once the table is full it overwrites the oldest entry.
- R10: While `train_filter_i` is 1, a resolution trains the direction counter only if its PC hits in the target buffer at that moment.
- R11: All statistics counters clear on reset and hold at their all-ones value instead of wrapping.
- R12: When a prediction and a resolution occur in the same cycle, the prediction uses the state before that resolution's update. If both touch the same target-buffer set, the resolution's write decides the replacement order. A prediction for the PC being resolved is scored on the old entry and is stored as the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Prediction request from fetch |
| pred_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted taken |
| pred_target_o | output | 32 | Predicted target when taken, else 0 |
| pred_next_pc_o | output | 32 | Predicted next fetch PC |
| res_valid_i | input | 1 | Resolved branch report from execute |
| res_pc_i | input | 32 | PC of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_target_i | input | 32 | Actual target |
| train_filter_i | input | 1 | Train direction only on target-buffer hit |
| stat_total_o | output | 32 | Prediction requests |
| stat_correct_o | output | 32 | Correctly scored resolutions |
| stat_mispred_o | output | 32 | Wrongly scored resolutions |
| stat_btb_hit_o | output | 32 | Target-buffer hits on prediction |
| stat_btb_miss_o | output | 32 | Target-buffer misses on prediction |

## Verification
The critical overlap is a prediction and a resolution landing in the same cycle. When both use the same PC, they read and write the same direction counter, the same target-buffer set and the same in-flight slot. The bench provokes this with directed cycles that predict a PC while resolving it, or while resolving a PC of the same set. It then adds a long mixed stretch in which both ports fire independently over a small pool of aliasing PCs. A reference model updates its state in the order the requirements define: read for the prediction first, then apply the resolution, then the prediction's own side effects. The monitor compares every prediction output and every counter value, cycle by cycle, against that model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned BTB_WAYS = 2;  // one LRU bit per set
  localparam int unsigned WAY_W = 1;

  typedef logic [1:0] dir_cnt_t;
  localparam dir_cnt_t DIR_RESET = 2'd1;

  localparam int unsigned NUM_STATS  = 5;
  localparam int unsigned ST_TOTAL   = 0;
  localparam int unsigned ST_CORRECT = 1;
  localparam int unsigned ST_MISPRED = 2;
  localparam int unsigned ST_HIT     = 3;
  localparam int unsigned ST_MISS    = 4;

  function automatic dir_cnt_t dir_train(dir_cnt_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf import bp_pkg::*; #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned SETS = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // lookup port A: prediction
  input  logic [PC_W-1:0]  la_pc_i,
  input  logic             la_touch_i,
  output logic             la_hit_o,
  output logic [PC_W-1:0]  la_target_o,
  // lookup port B: resolution, also the write address
  input  logic [PC_W-1:0]  lb_pc_i,
  output logic             lb_hit_o,
  input  logic             wr_i,
  input  logic [PC_W-1:0]  wr_target_i
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = PC_W - SET_W - 1;

  logic             vld_q [SETS][BTB_WAYS];
  logic [TAG_W-1:0] tag_q [SETS][BTB_WAYS];
  logic [PC_W-1:0]  tgt_q [SETS][BTB_WAYS];
  logic [WAY_W-1:0] lru_q [SETS];  // way to evict next

  logic [SET_W-1:0] set_a, set_b;
  logic [TAG_W-1:0] tag_a, tag_b;
  logic [WAY_W-1:0] way_a, way_b, victim, wr_way;

  assign set_a = SET_W'(la_pc_i >> 1);
  assign set_b = SET_W'(lb_pc_i >> 1);
  assign tag_a = TAG_W'(la_pc_i >> (SET_W + 1));
  assign tag_b = TAG_W'(lb_pc_i >> (SET_W + 1));

  always_comb begin
    la_hit_o    = 1'b0;
    way_a       = '0;
    la_target_o = '0;
    for (int w = 0; w < BTB_WAYS; w++) begin
      if (!la_hit_o && vld_q[set_a][w] && tag_q[set_a][w] == tag_a) begin
        la_hit_o    = 1'b1;
        way_a       = WAY_W'(w);
        la_target_o = tgt_q[set_a][w];
      end
    end
  end

  always_comb begin
    lb_hit_o = 1'b0;
    way_b    = '0;
    for (int w = 0; w < BTB_WAYS; w++) begin
      if (!lb_hit_o && vld_q[set_b][w] && tag_q[set_b][w] == tag_b) begin
        lb_hit_o = 1'b1;
        way_b    = WAY_W'(w);
      end
    end
  end

  // empty ways first, lowest index wins; else LRU
  always_comb begin
    victim = lru_q[set_b];
    for (int w = BTB_WAYS - 1; w >= 0; w--)
      if (!vld_q[set_b][w]) victim = WAY_W'(w);
    wr_way = lb_hit_o ? way_b : victim;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= '0;
        for (int w = 0; w < BTB_WAYS; w++) vld_q[s][w] <= 1'b0;
      end
    end else begin
      if (wr_i) begin
        vld_q[set_b][wr_way] <= 1'b1;
        lru_q[set_b]         <= ~wr_way;
      end
      // write wins the replacement order on a shared set
      if (la_touch_i && la_hit_o && !(wr_i && set_a == set_b))
        lru_q[set_a] <= ~way_a;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_q[set_b][wr_way] <= tag_b;
      tgt_q[set_b][wr_way] <= wr_target_i;
    end
  end
endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table import bp_pkg::*; #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            rd_taken_o,
  input  logic            wr_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic            wr_taken_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  dir_cnt_t         cnt_q [ENTRIES];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx     = IDX_W'(rd_pc_i >> 1);
  assign wr_idx     = IDX_W'(wr_pc_i >> 1);
  assign rd_taken_o = cnt_q[rd_idx][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= DIR_RESET;
    end else if (wr_i) begin
      cnt_q[wr_idx] <= dir_train(cnt_q[wr_idx], wr_taken_i);
    end
  end
endmodule

// File: rtl/bp_inflight.sv
module bp_inflight #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ins_i,
  input  logic [PC_W-1:0] ins_pc_i,
  input  logic            ins_taken_i,
  input  logic [PC_W-1:0] ins_target_i,
  input  logic            rm_i,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_found_o,
  output logic            lk_taken_o,
  output logic [PC_W-1:0] lk_target_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic            vld;
    logic [PC_W-1:0] pc;
    logic            taken;
    logic [PC_W-1:0] target;
  } entry_t;

  entry_t           ent_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, slot;
  logic [DEPTH-1:0] ins_hit, lk_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign ins_hit[i] = ent_q[i].vld && ent_q[i].pc == ins_pc_i;
    assign lk_hit[i]  = ent_q[i].vld && ent_q[i].pc == lk_pc_i;
  end

  always_comb begin
    slot = ptr_q;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (ins_hit[i]) slot = PTR_W'(i);
  end

  always_comb begin
    lk_found_o  = |lk_hit;
    lk_taken_o  = 1'b0;
    lk_target_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_hit[i]) begin
        lk_taken_o  = ent_q[i].taken;
        lk_target_o = ent_q[i].target;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_i && slot == PTR_W'(i))
          ent_q[i] <= '{vld: 1'b1, pc: ins_pc_i, taken: ins_taken_i, target: ins_target_i};
        else if (rm_i && lk_hit[i])
          ent_q[i].vld <= 1'b0;
      end
      if (ins_i && !(|ins_hit))
        ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl import bp_pkg::*; #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned BTB_SETS    = 128,
  parameter int unsigned BHT_ENTRIES = 512,
  parameter int unsigned INFLIGHT    = 4,
  parameter int unsigned FETCH_WIDTH = 4,
  parameter int unsigned INST_BYTES  = 4,
  parameter int unsigned CNT_W       = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pred_req_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  pred_target_o,
  output logic [PC_W-1:0]  pred_next_pc_o,
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic             res_taken_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             train_filter_i,
  output logic [CNT_W-1:0] stat_total_o,
  output logic [CNT_W-1:0] stat_correct_o,
  output logic [CNT_W-1:0] stat_mispred_o,
  output logic [CNT_W-1:0] stat_btb_hit_o,
  output logic [CNT_W-1:0] stat_btb_miss_o
);
  localparam int unsigned FALL = FETCH_WIDTH * INST_BYTES;

  logic            btb_hit_a, btb_hit_b, dir_taken, dir_wr;
  logic [PC_W-1:0] btb_tgt_a;
  logic            inf_found, inf_taken, score_ok;
  logic [PC_W-1:0] inf_target;

  bp_target_buf #(.PC_W(PC_W), .SETS(BTB_SETS)) u_btb (
    .clk_i, .rst_ni,
    .la_pc_i     (pred_pc_i),
    .la_touch_i  (pred_req_i),
    .la_hit_o    (btb_hit_a),
    .la_target_o (btb_tgt_a),
    .lb_pc_i     (res_pc_i),
    .lb_hit_o    (btb_hit_b),
    .wr_i        (res_valid_i && res_taken_i),
    .wr_target_i (res_target_i)
  );

  assign dir_wr = res_valid_i && (!train_filter_i || btb_hit_b);

  bp_dir_table #(.PC_W(PC_W), .ENTRIES(BHT_ENTRIES)) u_dir (
    .clk_i, .rst_ni,
    .rd_pc_i    (pred_pc_i),
    .rd_taken_o (dir_taken),
    .wr_i       (dir_wr),
    .wr_pc_i    (res_pc_i),
    .wr_taken_i (res_taken_i)
  );

  assign pred_taken_o   = btb_hit_a && dir_taken;
  assign pred_target_o  = pred_taken_o ? btb_tgt_a : '0;
  assign pred_next_pc_o = pred_taken_o ? btb_tgt_a : pred_pc_i + PC_W'(FALL);

  bp_inflight #(.PC_W(PC_W), .DEPTH(INFLIGHT)) u_inf (
    .clk_i, .rst_ni,
    .ins_i        (pred_req_i),
    .ins_pc_i     (pred_pc_i),
    .ins_taken_i  (pred_taken_o),
    .ins_target_i (pred_target_o),
    .rm_i         (res_valid_i),
    .lk_pc_i      (res_pc_i),
    .lk_found_o   (inf_found),
    .lk_taken_o   (inf_taken),
    .lk_target_o  (inf_target)
  );

  assign score_ok = (inf_taken == res_taken_i) &&
                    (!res_taken_i || inf_target == res_target_i);

  logic [NUM_STATS-1:0] stat_inc;
  logic [CNT_W-1:0]     stat_cnt [NUM_STATS];

  assign stat_inc[ST_TOTAL]   = pred_req_i;
  assign stat_inc[ST_HIT]     = pred_req_i && btb_hit_a;
  assign stat_inc[ST_MISS]    = pred_req_i && !btb_hit_a;
  assign stat_inc[ST_CORRECT] = res_valid_i && inf_found && score_ok;
  assign stat_inc[ST_MISPRED] = res_valid_i && inf_found && !score_ok;

  for (genvar g = 0; g < NUM_STATS; g++) begin : g_stat
    bp_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i, .rst_ni,
      .inc_i (stat_inc[g]),
      .cnt_o (stat_cnt[g])
    );
  end

  assign stat_total_o    = stat_cnt[ST_TOTAL];
  assign stat_correct_o  = stat_cnt[ST_CORRECT];
  assign stat_mispred_o  = stat_cnt[ST_MISPRED];
  assign stat_btb_hit_o  = stat_cnt[ST_HIT];
  assign stat_btb_miss_o = stat_cnt[ST_MISS];
endmodule

// File: rtl/bp_ctrl_chk.sv
module bp_ctrl_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned FALL  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pred_req_i,
  input logic [PC_W-1:0]  pred_pc_i,
  input logic             pred_taken_o,
  input logic [PC_W-1:0]  pred_target_o,
  input logic [PC_W-1:0]  pred_next_pc_o,
  input logic             btb_hit,
  input logic             dir_taken,
  input logic [CNT_W-1:0] stat_total_o,
  input logic [CNT_W-1:0] stat_correct_o,
  input logic [CNT_W-1:0] stat_mispred_o,
  input logic [CNT_W-1:0] stat_btb_hit_o,
  input logic [CNT_W-1:0] stat_btb_miss_o
);
  a_r1_taken_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i && pred_taken_o |-> btb_hit && dir_taken);

  a_r2_next_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |-> pred_next_pc_o ==
      (pred_taken_o ? pred_target_o : pred_pc_i + PC_W'(FALL)));

  a_r3_total_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i && stat_total_o != '1 |=> stat_total_o == $past(stat_total_o) + 1'b1);

  a_r3_total_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> $stable(stat_total_o));

  a_r4_hit_miss_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_total_o != '1 |->
      ({1'b0, stat_btb_hit_o} + {1'b0, stat_btb_miss_o}) == {1'b0, stat_total_o});

  a_r7_one_score: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_correct_o != '1 && stat_mispred_o != '1 |=>
      ({1'b0, stat_correct_o} + {1'b0, stat_mispred_o}) <=
      ({1'b0, $past(stat_correct_o)} + {1'b0, $past(stat_mispred_o)} + 1'b1));

  a_r11_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_total_o == '1 |=> stat_total_o == '1);
endmodule

bind bp_ctrl bp_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W), .FALL(FETCH_WIDTH * INST_BYTES)) u_chk (
  .clk_i, .rst_ni, .pred_req_i, .pred_pc_i, .pred_taken_o, .pred_target_o,
  .pred_next_pc_o,
  .btb_hit   (btb_hit_a),
  .dir_taken (dir_taken),
  .stat_total_o, .stat_correct_o, .stat_mispred_o, .stat_btb_hit_o, .stat_btb_miss_o
);

// File: tb/tb_bp_ctrl.sv
module tb_bp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W = 3;
  localparam longint SMALL_MAX = 7;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        pred_req = 1'b0, res_valid = 1'b0, res_taken = 1'b0, filt = 1'b0;
  logic [31:0] pred_pc = '0, res_pc = '0, res_target = '0;
  logic        pred_taken;
  logic [31:0] pred_target, pred_next;
  logic [31:0] s_tot, s_cor, s_mis, s_hit, s_mss;
  logic        sm_taken;
  logic [31:0] sm_target, sm_next;
  logic [SMALL_W-1:0] m_tot, m_cor, m_mis, m_hit, m_mss;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bp_ctrl dut (
    .clk_i(clk), .rst_ni, .pred_req_i(pred_req), .pred_pc_i(pred_pc),
    .pred_taken_o(pred_taken), .pred_target_o(pred_target), .pred_next_pc_o(pred_next),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_target_i(res_target), .train_filter_i(filt),
    .stat_total_o(s_tot), .stat_correct_o(s_cor), .stat_mispred_o(s_mis),
    .stat_btb_hit_o(s_hit), .stat_btb_miss_o(s_mss));

  bp_ctrl #(.CNT_W(SMALL_W)) dut_small (
    .clk_i(clk), .rst_ni, .pred_req_i(pred_req), .pred_pc_i(pred_pc),
    .pred_taken_o(sm_taken), .pred_target_o(sm_target), .pred_next_pc_o(sm_next),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_target_i(res_target), .train_filter_i(filt),
    .stat_total_o(m_tot), .stat_correct_o(m_cor), .stat_mispred_o(m_mis),
    .stat_btb_hit_o(m_hit), .stat_btb_miss_o(m_mss));

  typedef struct {
    bit pv; bit tk; logic [31:0] tgt; logic [31:0] nxt;
    longint tot; longint cor; longint mis; longint hit; longint mss;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  bit          mv [128][2];
  logic [23:0] mtag [128][2];
  logic [31:0] mtgt [128][2];
  bit          mlru [128];
  int          mbht [512];
  bit          iv [4];
  logic [31:0] ipc [4];
  logic [31:0] itg [4];
  bit          itk [4];
  int          iptr = 0;
  longint      c_tot = 0, c_cor = 0, c_mis = 0, c_hit = 0, c_mss = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  function automatic longint sat(longint v);
    return (v > SMALL_MAX) ? SMALL_MAX : v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit pv, input logic [31:0] pp, input bit rv,
                      input logic [31:0] rp, input bit rt, input logic [31:0] rg,
                      input bit flt);
    exp_t e;
    int sa, sb, wa, wb, ws, slot, fnd;
    bit ha, hb, ok;
    @(posedge clk); #1;
    pred_req = pv; pred_pc = pp; res_valid = rv; res_pc = rp;
    res_taken = rt; res_target = rg; filt = flt;
    sa = int'(pp[7:1]); ha = 0; wa = 0;
    for (int w = 0; w < 2; w++)
      if (!ha && mv[sa][w] && mtag[sa][w] == pp[31:8]) begin ha = 1; wa = w; end
    e.pv = pv;
    e.tk = ha && (mbht[int'(pp[9:1])] >= 2);
    e.tgt = e.tk ? mtgt[sa][wa] : 32'h0;
    e.nxt = e.tk ? e.tgt : pp + 32'd16;
    e.tot = c_tot; e.cor = c_cor; e.mis = c_mis; e.hit = c_hit; e.mss = c_mss;
    exp_q.push_back(e);
    sb = int'(rp[7:1]); hb = 0; wb = 0;
    for (int w = 0; w < 2; w++)
      if (!hb && mv[sb][w] && mtag[sb][w] == rp[31:8]) begin hb = 1; wb = w; end
    slot = -1;
    if (pv) for (int i = 0; i < 4; i++) if (slot < 0 && iv[i] && ipc[i] == pp) slot = i;
    if (rv) begin
      fnd = -1;
      for (int i = 0; i < 4; i++) if (fnd < 0 && iv[i] && ipc[i] == rp) fnd = i;
      if (fnd >= 0) begin
        ok = (itk[fnd] == rt) && (!rt || itg[fnd] == rg);
        if (ok) c_cor++; else c_mis++;
        iv[fnd] = 0;
      end
      if (!flt || hb) begin
        if (rt && mbht[int'(rp[9:1])] < 3) mbht[int'(rp[9:1])]++;
        else if (!rt && mbht[int'(rp[9:1])] > 0) mbht[int'(rp[9:1])]--;
      end
      if (rt) begin
        ws = hb ? wb : (!mv[sb][0] ? 0 : (!mv[sb][1] ? 1 : int'(mlru[sb])));
        mv[sb][ws] = 1; mtag[sb][ws] = rp[31:8]; mtgt[sb][ws] = rg;
        mlru[sb] = (ws == 0);
      end
    end
    if (pv) begin
      c_tot++;
      if (ha) c_hit++; else c_mss++;
      if (ha && !(rv && rt && sa == sb)) mlru[sa] = (wa == 0);
      if (slot < 0) begin slot = iptr; iptr = (iptr + 1) % 4; end
      iv[slot] = 1; ipc[slot] = pp; itk[slot] = e.tk; itg[slot] = e.tgt;
    end
  endtask

  task automatic idle();
    step(0, 32'h0, 0, 32'h0, 0, 32'h0, 0);
  endtask

  // monitor: compares at the falling edge, after inputs settle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.pv) begin
        chk("R1 R5 R10 R12 pred_taken", longint'(pred_taken), longint'(e.tk));
        chk("R1 R6 pred_target", longint'(pred_target), longint'(e.tgt));
        chk("R2 pred_next_pc", longint'(pred_next), longint'(e.nxt));
      end
      chk("R3 stat_total", longint'(s_tot), e.tot);
      chk("R7 R8 R9 stat_correct", longint'(s_cor), e.cor);
      chk("R7 R8 R9 stat_mispred", longint'(s_mis), e.mis);
      chk("R4 R6 stat_btb_hit", longint'(s_hit), e.hit);
      chk("R4 stat_btb_miss", longint'(s_mss), e.mss);
      chk("R11 sat total", longint'(m_tot), sat(e.tot));
      chk("R11 sat correct", longint'(m_cor), sat(e.cor));
      chk("R11 sat mispred", longint'(m_mis), sat(e.mis));
      chk("R11 sat hit", longint'(m_hit), sat(e.hit));
      chk("R11 sat miss", longint'(m_mss), sat(e.mss));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h1000, PC2 = 32'h1100, PD = 32'h1200, PE = 32'h1400;

  initial begin
    int r;
    for (int s = 0; s < 128; s++) begin mlru[s] = 0; mv[s][0] = 0; mv[s][1] = 0; end
    for (int i = 0; i < 512; i++) mbht[i] = 1;
    for (int i = 0; i < 4; i++) iv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R11: reset state of counters
    idle();
    // R1 R2: cold miss gives fall-through
    step(1, PA, 0, 0, 0, 0, 0);
    // R7: taken resolve of a not-taken prediction -> mispredict, R6 allocate
    step(0, 0, 1, PA, 1, 32'h2000, 0);
    // R5: counter 2 now, hit -> taken
    step(1, PA, 0, 0, 0, 0, 0);
    step(0, 0, 1, PA, 1, 32'h2000, 0);   // R7 correct
    step(1, PA, 0, 0, 0, 0, 0);
    step(0, 0, 1, PA, 0, 32'h1010, 0);   // R7 direction wrong
    // R8: resolve with no stored prediction, and repeated resolve
    step(0, 0, 1, PA, 1, 32'h2000, 0);
    step(0, 0, 1, 32'h1002, 0, 0, 0);
    // R7: target mismatch
    step(1, PA, 0, 0, 0, 0, 0);
    step(0, 0, 1, PA, 1, 32'h3000, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    // R5 saturation up then down
    repeat (4) step(0, 0, 1, PA, 1, 32'h3000, 0);
    repeat (2) step(0, 0, 1, PA, 0, 0, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    repeat (3) step(0, 0, 1, PA, 0, 0, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    step(0, 0, 1, PA, 1, 32'h3000, 0);
    step(0, 0, 1, PA, 1, 32'h3000, 0);
    // R6: LRU across three PCs of one set
    step(0, 0, 1, PC2, 1, 32'h5000, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    step(0, 0, 1, PD, 1, 32'h6000, 0);
    step(1, PC2, 0, 0, 0, 0, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    step(1, PD, 0, 0, 0, 0, 0);
    // R12: predict and resolve the same PC in one cycle
    step(1, PA, 1, PA, 1, 32'h3000, 0);
    step(1, PA, 1, PA, 0, 0, 0);
    step(1, PD, 1, PC2, 1, 32'h5000, 0);
    step(1, PC2, 0, 0, 0, 0, 0);
    // R9: overflow of the in-flight table
    for (int k = 0; k < 5; k++) step(1, 32'h8000 + 32'(k * 32), 0, 0, 0, 0, 0);
    step(1, 32'h8020, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 32'h8000 + 32'(k * 32), 0, 0, 0);
    // R10: filtered training keeps aliased counter of PA
    step(0, 0, 1, PA, 1, 32'h3000, 0);
    step(0, 0, 1, PA, 1, 32'h3000, 0);
    repeat (4) step(0, 0, 1, PE, 0, 0, 1);
    step(1, PA, 0, 0, 0, 0, 0);
    repeat (4) step(0, 0, 1, PE, 0, 0, 0);
    step(1, PA, 0, 0, 0, 0, 0);
    // mixed traffic over an aliasing pool, R12 overlaps included
    r = 32'h1234567;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      a = 32'h1000 + (32'(r[2:0]) << 8) + (32'(r[3]) << 1);
      b = 32'h1000 + (32'(r[6:4]) << 8) + (32'(r[7]) << 1);
      step(r[8], a, r[9] | r[10], b, r[11], 32'h4000 + (32'(r[13:12]) << 4), r[14] & r[15]);
    end
    idle();
    idle();
    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule